// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table kept in a synchronous memory. A requester presents an address with a valid/ready handshake, together with the base address of the top-level (outer) table. The walker issues one memory read to fetch the outer entry. If that entry is valid, it issues a second read to fetch the inner entry from the table the outer entry points to.

The result comes back on a response handshake. It carries either the translated physical address, which is the inner entry's frame number joined to the untouched 12-bit page offset, or a fault flag with a level code that names the table holding the invalid entry. Only one walk is in flight at a time. The memory answers every read exactly one cycle after it is issued.

Top module: `ptw_top`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.
- R2: A request is accepted only when `req_valid` and `req_ready` are both 1 at a clock edge. `req_ready` stays 0 from that edge until the edge at which the response is taken. Requests offered during a walk are neither read nor answered.
- R3: In the cycle a request is accepted, the walker reads address `root_base + vaddr[31:22]*4`.
- R4: When the outer entry is valid, the walker reads address `{outer_entry[31:12], 12'h000} + vaddr[21:12]*4` in the following cycle.
- R5: When both entries are valid, the response has `rsp_paddr = {inner_entry[31:12], vaddr[11:0]}`, `rsp_fault = 0` and `rsp_fault_level = 0`. `rsp_valid` rises on the third clock edge after acceptance.
- R6: An entry is valid when its bit 0 is 1. If the outer entry has bit 0 equal to 0, the response has `rsp_fault = 1`, `rsp_fault_level = 1` and `rsp_paddr = 0`. It appears on the second edge after acceptance, and no second read is issued.
- R7: If the outer entry is valid and the inner entry has bit 0 equal to 0, the response has `rsp_fault = 1`, `rsp_fault_level = 2` and `rsp_paddr = 0`, after exactly two reads.
- R8: Bits 11:1 of either entry have no effect on the read addresses or on the response.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, the response fields hold steady and no memory read is issued. When the response is taken, `rsp_valid` drops and `req_ready` returns to 1 on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 32 | Byte address of the outer table, sampled at acceptance |
| mem_rd_en | output | 1 | Table memory read strobe |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_data | input | 32 | Entry returned one cycle after the strobe |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_fault_level | output | 2 | 0 none, 1 outer table, 2 inner table |

## Verification
The bench uses the package defaults: 32-bit addresses, a 12-bit offset and two 10-bit indices. With these values, the corner indices 0 and 1023 at both levels can be reached with real table contents, so the bench can check that the index scaling carries into the upper address bits. A sparse memory model records every read address, so the exact read sequence and read count of each walk, including the missing second read on an outer fault, can be compared against the address formulas. Walks are repeated with invalid entries that hold nonzero frames, with entries whose middle bits are all ones, with two different table bases, and with the response held back while new requests keep arriving.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W      = 32;
    localparam int PA_W      = 32;
    localparam int PTE_W     = 32;
    localparam int OFF_W     = 12;
    localparam int IDX_W     = 10;
    localparam int ENT_SHIFT = 2;
    localparam int FRAME_W   = PA_W - OFF_W;
    localparam int RSV_W     = OFF_W - 1;

    typedef struct packed {
        logic [IDX_W-1:0] outer;
        logic [IDX_W-1:0] inner;
        logic [OFF_W-1:0] off;
    } vaddr_t;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic [RSV_W-1:0]   rsvd;
        logic               valid;
    } pte_t;

    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_L1   = 2'd1,
        WALK_L2   = 2'd2,
        WALK_RESP = 2'd3
    } walk_state_e;

    typedef enum logic [1:0] {
        FLVL_NONE  = 2'd0,
        FLVL_OUTER = 2'd1,
        FLVL_INNER = 2'd2
    } flt_lvl_e;

    function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] tbl,
                                                   input logic [IDX_W-1:0] idx);
        logic [PA_W-1:0] scaled;
        scaled = '0;
        scaled[IDX_W+ENT_SHIFT-1:0] = {idx, {ENT_SHIFT{1'b0}}};
        return tbl + scaled;
    endfunction

endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0]   raw,
    output logic               ent_valid,
    output logic [FRAME_W-1:0] ent_frame
);
    pte_t ent;
    logic rsvd_unused;

    assign ent         = pte_t'(raw);
    assign ent_valid   = ent.valid;
    assign ent_frame   = ent.frame;
    assign rsvd_unused = ^ent.rsvd;
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic               sel_inner,
    input  logic [PA_W-1:0]    root_base,
    input  logic [FRAME_W-1:0] inner_frame,
    input  vaddr_t             va,
    output logic [PA_W-1:0]    rd_addr
);
    logic [PA_W-1:0] inner_tbl;

    assign inner_tbl = {inner_frame, {OFF_W{1'b0}}};
    assign rd_addr   = sel_inner ? entry_addr(inner_tbl, va.inner)
                                 : entry_addr(root_base, va.outer);
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [PA_W-1:0] root_base,
    output logic            mem_rd_en,
    output logic [PA_W-1:0] mem_rd_addr,
    input  logic [PTE_W-1:0] mem_rd_data,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            rsp_fault,
    output logic [1:0]      rsp_fault_level
);
    walk_state_e        state_q;
    vaddr_t             va_q;
    vaddr_t             va_sel;
    logic [PA_W-1:0]    paddr_q;
    logic               fault_q;
    flt_lvl_e           lvl_q;
    logic               ent_valid;
    logic [FRAME_W-1:0] ent_frame;
    logic               accept;

    ptw_pte_decode u_dec (
        .raw       (mem_rd_data),
        .ent_valid (ent_valid),
        .ent_frame (ent_frame)
    );

    // In IDLE the live request address drives the outer read; afterwards the captured one.
    assign va_sel = (state_q == WALK_IDLE) ? vaddr_t'(req_vaddr) : va_q;

    ptw_addr_gen u_agen (
        .sel_inner   (state_q == WALK_L1),
        .root_base   (root_base),
        .inner_frame (ent_frame),
        .va          (va_sel),
        .rd_addr     (mem_rd_addr)
    );

    assign accept    = (state_q == WALK_IDLE) && req_valid;
    assign mem_rd_en = accept || ((state_q == WALK_L1) && ent_valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WALK_IDLE;
            va_q    <= '0;
            paddr_q <= '0;
            fault_q <= 1'b0;
            lvl_q   <= FLVL_NONE;
        end else begin
            case (state_q)
                WALK_IDLE: begin
                    if (req_valid) begin
                        va_q    <= vaddr_t'(req_vaddr);
                        state_q <= WALK_L1;
                    end
                end
                WALK_L1: begin
                    if (!ent_valid) begin
                        paddr_q <= '0;
                        fault_q <= 1'b1;
                        lvl_q   <= FLVL_OUTER;
                        state_q <= WALK_RESP;
                    end else begin
                        state_q <= WALK_L2;
                    end
                end
                WALK_L2: begin
                    if (ent_valid) begin
                        paddr_q <= {ent_frame, va_q.off};
                        fault_q <= 1'b0;
                        lvl_q   <= FLVL_NONE;
                    end else begin
                        paddr_q <= '0;
                        fault_q <= 1'b1;
                        lvl_q   <= FLVL_INNER;
                    end
                    state_q <= WALK_RESP;
                end
                default: begin
                    if (rsp_ready) state_q <= WALK_IDLE;
                end
            endcase
        end
    end

    assign req_ready       = (state_q == WALK_IDLE);
    assign rsp_valid       = (state_q == WALK_RESP);
    assign rsp_paddr       = paddr_q;
    assign rsp_fault       = fault_q;
    assign rsp_fault_level = lvl_q;
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_rd_en,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_paddr,
    input logic        rsp_fault,
    input logic [1:0]  rsp_fault_level
);
    assert_busy_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    assert_lock_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_outer_read_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> mem_rd_en);

    assert_ok_level_R5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_fault) |-> (rsp_fault_level == 2'd0));

    assert_fault_fields_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |->
            ((rsp_fault_level == 2'd1 || rsp_fault_level == 2'd2) && rsp_paddr == 32'd0));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_fault_level)));

    assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !mem_rd_en);

    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));
endmodule

bind ptw_top ptw_checker u_chk (.*);

// File: tb/sim_ptw_top.sv
`timescale 1ns/1ps
module sim_ptw_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_vaddr;
    logic [31:0] root_base;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data;
    logic        rsp_valid;
    logic        rsp_ready;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_fault_level;

    int total = 0;
    int bad   = 0;

    logic [31:0] mem [int unsigned];
    logic [31:0] rd_log [4];
    int          rd_cnt;

    always #2 clk = ~clk;

    ptw_top u0 (.*);

    always @(posedge clk) begin
        if (mem_rd_en) begin
            if (rd_cnt < 4) rd_log[rd_cnt] = mem_rd_addr;
            rd_cnt = rd_cnt + 1;
            mem_rd_data <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 32'd0;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One full walk: offer at a negedge, wait for the response, optionally stall, then take it.
    task automatic walk(input logic [31:0] base, input logic [31:0] va, input int stall,
                        input logic spam, output logic [31:0] pa, output logic flt,
                        output logic [1:0] lvl, output int lat);
        @(negedge clk);
        root_base = base;
        req_vaddr = va;
        req_valid = 1'b1;
        rd_cnt    = 0;
        chk(req_ready === 1'b1, "R2 ready before accept", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        if (spam) req_vaddr = va ^ 32'h0040_0000;
        else      req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 10) begin
            chk(req_ready === 1'b0, "R2 busy during walk", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            lat++;
        end
        pa  = rsp_paddr;
        flt = rsp_fault;
        lvl = rsp_fault_level;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_paddr == pa && rsp_fault == flt && rsp_fault_level == lvl,
                "R9 held under backpressure", rsp_paddr, pa);
            chk(!mem_rd_en && !req_ready, "R9 no read while held", {31'd0, mem_rd_en}, 32'd0);
        end
        rsp_ready = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R9 release to idle", {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        req_valid = 1'b0; rsp_ready = 1'b0; req_vaddr = '0; root_base = '0;
        rd_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_rd_en, "R1 reset state",
            {29'd0, req_ready, rsp_valid, mem_rd_en}, 32'h4);
    endtask

    task automatic t_basic;
        logic [31:0] pa; logic f; logic [1:0] l; int lat;
        walk(32'h0001_0000, 32'h0040_3ABC, 0, 1'b0, pa, f, l, lat);
        chk(rd_log[0] == 32'h0001_0004, "R3 outer address", rd_log[0], 32'h0001_0004);
        chk(rd_log[1] == 32'h0002_000C, "R4 inner address", rd_log[1], 32'h0002_000C);
        chk(pa == 32'hABCD_EABC && !f && l == 2'd0, "R5 translation", pa, 32'hABCD_EABC);
        chk(lat == 3, "R5 latency", lat, 3);
        chk(rd_cnt == 2, "R4 two reads", rd_cnt, 2);
    endtask

    task automatic t_reserved;
        logic [31:0] pa; logic f; logic [1:0] l; int lat;
        walk(32'h0001_0000, 32'h0080_5123, 0, 1'b0, pa, f, l, lat);
        chk(rd_log[1] == 32'h0003_0014, "R8 inner address ignores middle bits", rd_log[1],
            32'h0003_0014);
        chk(pa == 32'h1234_5123 && !f, "R8 translation ignores middle bits", pa, 32'h1234_5123);
    endtask

    task automatic t_outer_fault;
        logic [31:0] pa; logic f; logic [1:0] l; int lat;
        walk(32'h0001_0000, 32'h01C0_0456, 0, 1'b0, pa, f, l, lat);
        chk(f && l == 2'd1, "R6 outer fault level", {30'd0, l}, 32'd1);
        chk(pa == 32'd0, "R6 outer fault address", pa, 32'd0);
        chk(rd_cnt == 1, "R6 single read", rd_cnt, 1);
        chk(lat == 2, "R6 latency", lat, 2);
    endtask

    task automatic t_inner_fault;
        logic [31:0] pa; logic f; logic [1:0] l; int lat;
        walk(32'h0001_0000, 32'h0040_9777, 0, 1'b0, pa, f, l, lat);
        chk(f && l == 2'd2 && pa == 32'd0, "R7 inner fault", {30'd0, l}, 32'd2);
        chk(rd_cnt == 2 && rd_log[1] == 32'h0002_0024, "R7 two reads", rd_log[1],
            32'h0002_0024);
    endtask

    task automatic t_edges;
        logic [31:0] pa; logic f; logic [1:0] l; int lat;
        walk(32'h0001_0000, 32'hFFFF_FFFF, 0, 1'b0, pa, f, l, lat);
        chk(rd_log[0] == 32'h0001_0FFC, "R3 top outer index", rd_log[0], 32'h0001_0FFC);
        chk(rd_log[1] == 32'h0005_0FFC, "R4 top inner index", rd_log[1], 32'h0005_0FFC);
        chk(pa == 32'hFEDC_BFFF && !f, "R5 top indices", pa, 32'hFEDC_BFFF);
        walk(32'h0020_0000, 32'h0000_0FED, 0, 1'b0, pa, f, l, lat);
        chk(rd_log[0] == 32'h0020_0000, "R3 second base", rd_log[0], 32'h0020_0000);
        chk(pa == 32'h7777_7FED && !f, "R5 zero indices", pa, 32'h7777_7FED);
    endtask

    task automatic t_backpressure;
        logic [31:0] pa; logic f; logic [1:0] l; int lat;
        walk(32'h0001_0000, 32'h0040_3ABC, 4, 1'b1, pa, f, l, lat);
        chk(rd_cnt == 2, "R2 offered request ignored during walk", rd_cnt, 2);
        chk(pa == 32'hABCD_EABC, "R9 response for first request", pa, 32'hABCD_EABC);
    endtask

    initial begin
        mem[32'h0001_0004] = 32'h0002_0001;
        mem[32'h0002_000C] = 32'hABCD_E001;
        mem[32'h0001_0008] = 32'h0003_0FFF;
        mem[32'h0003_0014] = 32'h1234_5FFF;
        mem[32'h0001_001C] = 32'h0004_0FFE;
        mem[32'h0001_0FFC] = 32'h0005_0001;
        mem[32'h0005_0FFC] = 32'hFEDC_B001;
        mem[32'h0020_0000] = 32'h0006_0001;
        mem[32'h0006_0000] = 32'h7777_7001;
        t_reset();
        t_basic();
        t_reserved();
        t_outer_fault();
        t_inner_fault();
        t_edges();
        t_backpressure();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule